// File: doc/BRIEF.md
# Framed PRBS Test Pattern Checker

This block takes a received T1 or E1 serial bit stream and compares it against one of four selectable pseudo-random binary sequences. It first hunts for the sequence by loading its local shift register straight from the incoming bits. Once enough predicted bits agree in a row, it declares lock. From then on the register runs freely, and every disagreement between the prediction and the received bit is counted as a bit error.

Frame positions come in on input pins; the block does not recover framing itself. In framed operation, the framing overhead positions are left out of both the hunt and the check. These are the T1 frame bit, E1 time slot 0, and also E1 time slot 16 when channel-associated signalling is in use. An optional zero limit caps the run of zeros the expected sequence may contain. The error counter has two modes. In the first it is cleared by a read strobe. In the second it is snapshotted into a holding register on a one-second tick, and the live count restarts.

Top module: `prbs_rx_checker`

## Requirements
- R1: The pattern select picks the sequence: 0 gives b[i]=b[i-11]^b[i-9], 1 gives b[i]=b[i-15]^b[i-14], 2 gives b[i]=b[i-20]^b[i-3], and 3 gives b[i]=b[i-23]^b[i-18]. After a reseed, an error-free stream raises `sync` once the register has filled and 32 consecutive checked bits have matched.
- R2: Bit errors are counted only while locked; mismatches seen during the hunt never reach the counter.
- R3: With `framed_en`=1 and `mode_e1`=0, any bit flagged by `t1_fbit` is neither loaded, compared nor counted.
- R4: With `framed_en`=1 and `mode_e1`=1, bits with `e1_ts`=0 are skipped. Bits with `e1_ts`=16 are also skipped when `cas_en`=1, and are checked when `cas_en`=0.
- R5: With `framed_en`=0, every valid bit is hunted and checked, whatever the framing inputs show.
- R6: While `start_en`=0, `sync` is 0 and the counter does not change. Raising `start_en` does not start a hunt; only a `reseed` pulse does.
- R7: A `reseed` pulse drops `sync` on the next clock and restarts the hunt from the bits that follow.
- R8: While locked, the checked bits are grouped into consecutive windows of 64, starting with the first bit after lock. If 8 errors fall inside one window, lock is dropped and a new hunt starts by itself. A window with 7 errors keeps lock.
- R9: With `latch_mode`=0, `err_cnt` shows the live count, and `cnt_rd` returns it to zero.
- R10: With `latch_mode`=1, `sec_tick` copies the live count into a holding register and restarts the live count. `err_cnt` shows the held value, which stays fixed between ticks.
- R11: The counter saturates at all ones. `ovf_irq` pulses for one cycle on the step into saturation, and only once.
- R12: With `zero_lim`=N (N>0), an expected bit that follows N expected zeros is forced to 1. The shift register still advances on the unforced value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Received serial data bit |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| t1_fbit | input | 1 | Current bit is the T1 frame bit |
| e1_ts | input | 5 | E1 time slot of the current bit |
| mode_e1 | input | 1 | 1 = E1 line, 0 = T1 line |
| cas_en | input | 1 | E1 signalling in slot 16 |
| pat_sel | input | 2 | Sequence select (see R1) |
| zero_lim | input | ZL_W (4) | Maximum run of expected zeros, 0 = no limit |
| framed_en | input | 1 | Skip framing overhead positions |
| start_en | input | 1 | Enables the checker and error counting |
| reseed | input | 1 | One-cycle pulse that starts or restarts the hunt |
| latch_mode | input | 1 | 0 = clear on read, 1 = snapshot on tick |
| sec_tick | input | 1 | One-second tick |
| cnt_rd | input | 1 | Counter read strobe |
| sync | output | 1 | Pattern lock status |
| err_cnt | output | CNT_W (16) | Error count (live or held) |
| ovf_irq | output | 1 | One-cycle saturation pulse |

## Verification
The checker is driven with error-free sequences for every pattern length. These run unframed, T1-framed, E1-framed without signalling and E1-framed with signalling, and the overhead positions carry toggling filler. A skip at the wrong position therefore shows up as failed lock or stray errors, and a skip that is missing does the same. Isolated injected errors tell whether only payload mismatches are counted. Bursts of 7 and 8 errors aligned to a window tell the lock-loss threshold apart. Garbage during the hunt tells whether counting before lock is blocked. A long run with the zero limit active tells whether the forced-one rule matches, and a stream of about a thousand errors tells whether saturation and the single overflow pulse behave.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

  localparam int SR_W  = 23;
  localparam int LEN_W = $clog2(SR_W + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HUNT = 2'd1,
    ST_LOCK = 2'd2
  } lock_st_e;

  // register length per pattern select
  function automatic logic [LEN_W-1:0] pat_len(input logic [1:0] sel);
    case (sel)
      2'd0:    return LEN_W'(11);
      2'd1:    return LEN_W'(15);
      2'd2:    return LEN_W'(20);
      default: return LEN_W'(23);
    endcase
  endfunction

  // r[k-1] holds the bit received k positions ago
  function automatic logic pat_fb(input logic [SR_W-1:0] r, input logic [1:0] sel);
    case (sel)
      2'd0:    return r[10] ^ r[8];
      2'd1:    return r[14] ^ r[13];
      2'd2:    return r[19] ^ r[2];
      default: return r[22] ^ r[17];
    endcase
  endfunction

endpackage

// File: rtl/prbs_slot_gate.sv
module prbs_slot_gate #(
  parameter int TS_W   = 5,
  parameter int FAS_TS = 0,
  parameter int SIG_TS = 16
) (
  input  logic            bit_vld,
  input  logic            framed_en,
  input  logic            mode_e1,
  input  logic            cas_en,
  input  logic            t1_fbit,
  input  logic [TS_W-1:0] e1_ts,
  output logic            use_bit
);

  localparam logic [TS_W-1:0] FAS_SLOT = TS_W'(FAS_TS);
  localparam logic [TS_W-1:0] SIG_SLOT = TS_W'(SIG_TS);

  logic e1_ovh;
  logic ovh;

  // R4: slot 0 always overhead, slot 16 only with signalling
  assign e1_ovh = (e1_ts == FAS_SLOT) || (cas_en && (e1_ts == SIG_SLOT));
  // R3: T1 frame bit position
  assign ovh    = mode_e1 ? e1_ovh : t1_fbit;
  // R5: unframed uses every valid bit
  assign use_bit = bit_vld && !(framed_en && ovh);

endmodule

// File: rtl/prbs_lock_engine.sv
module prbs_lock_engine
  import prbs_chk_pkg::*;
#(
  parameter int LOCK_RUN = 32,
  parameter int WIN_LEN  = 64,
  parameter int WIN_ERR  = 8,
  parameter int ZL_W     = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            use_bit,
  input  logic            rx_bit,
  input  logic            start_en,
  input  logic            reseed,
  input  logic [1:0]      pat_sel,
  input  logic [ZL_W-1:0] zero_lim,
  output logic            sync_o,
  output logic            err_o
);

  localparam int MR_W = $clog2(LOCK_RUN + 1);
  localparam int WL_W = $clog2(WIN_LEN);
  localparam int WE_W = $clog2(WIN_ERR + 1);
  localparam int ZR_W = ZL_W + 1;
  localparam logic [MR_W-1:0] MR_LAST  = MR_W'(LOCK_RUN - 1);
  localparam logic [WL_W-1:0] WL_LAST  = WL_W'(WIN_LEN - 1);
  localparam logic [WE_W:0]   WE_LIMIT = (WE_W+1)'(WIN_ERR);

  lock_st_e          st;
  logic [SR_W-1:0]   shreg;
  logic [LEN_W-1:0]  fill;
  logic [LEN_W-1:0]  len;
  logic [MR_W-1:0]   match;
  logic [WL_W-1:0]   wcnt;
  logic [WE_W-1:0]   werr;
  logic [WE_W:0]     wsum;
  logic [ZR_W-1:0]   zrun;
  logic              raw;
  logic              force_one;
  logic              exp_bit;
  logic              miss;

  function automatic logic [ZR_W-1:0] zr_step(input logic [ZR_W-1:0] z, input logic b);
    if (b)           return '0;
    else if (&z)     return z;
    else             return z + 1'b1;
  endfunction

  assign len       = pat_len(pat_sel);
  assign raw       = pat_fb(shreg, pat_sel);
  // R12: force a one after zero_lim expected zeros
  assign force_one = (zero_lim != '0) && (zrun >= ZR_W'(zero_lim));
  assign exp_bit   = force_one | raw;
  assign miss      = exp_bit ^ rx_bit;
  assign wsum      = {1'b0, werr} + (WE_W+1)'(miss);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      shreg  <= '0;
      fill   <= '0;
      match  <= '0;
      wcnt   <= '0;
      werr   <= '0;
      zrun   <= '0;
      sync_o <= 1'b0;
      err_o  <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (!start_en) begin
        st     <= ST_IDLE;
        sync_o <= 1'b0;
      end else if (reseed) begin
        st     <= ST_HUNT;
        fill   <= '0;
        match  <= '0;
        sync_o <= 1'b0;
      end else if (use_bit) begin
        case (st)
          ST_HUNT: begin
            shreg <= {shreg[SR_W-2:0], rx_bit};
            zrun  <= zr_step(zrun, rx_bit);
            if (fill < len) begin
              fill  <= fill + 1'b1;
              match <= '0;
            end else if (!miss) begin
              if (match == MR_LAST) begin
                st     <= ST_LOCK;
                sync_o <= 1'b1;
                wcnt   <= '0;
                werr   <= '0;
              end else begin
                match <= match + 1'b1;
              end
            end else begin
              match <= '0;
            end
          end
          ST_LOCK: begin
            shreg <= {shreg[SR_W-2:0], raw};
            zrun  <= zr_step(zrun, exp_bit);
            err_o <= miss;
            if (wsum >= WE_LIMIT) begin
              st     <= ST_HUNT;
              sync_o <= 1'b0;
              fill   <= '0;
              match  <= '0;
            end else if (wcnt == WL_LAST) begin
              wcnt <= '0;
              werr <= '0;
            end else begin
              wcnt <= wcnt + 1'b1;
              werr <= wsum[WE_W-1:0];
            end
          end
          default: ;
        endcase
      end
    end
  end

  p_start_gate_r6: assert property (@(posedge clk) disable iff (rst)
    !start_en |=> !sync_o);

  p_reseed_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (start_en && reseed) |=> !sync_o);

  p_err_locked_r2: assert property (@(posedge clk) disable iff (rst)
    err_o |-> $past(sync_o));

  p_lock_on_bit_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(sync_o) |-> $past(use_bit));

endmodule

// File: rtl/prbs_err_counter.sv
module prbs_err_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             latch_mode,
  input  logic             rd_clr,
  input  logic             tick,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] C_MAX = '1;
  localparam logic [CNT_W-1:0] C_PRE = C_MAX - 1'b1;

  logic [CNT_W-1:0] live;
  logic [CNT_W-1:0] hold;
  logic             restart;

  // R9 / R10: the restart source follows the mode
  assign restart = latch_mode ? tick : rd_clr;

  always_ff @(posedge clk) begin
    if (rst) begin
      live  <= '0;
      hold  <= '0;
      ovf_o <= 1'b0;
    end else begin
      ovf_o <= 1'b0;
      if (latch_mode && tick)
        hold <= live;
      if (restart) begin
        live <= CNT_W'(inc);
      end else if (inc && (live != C_MAX)) begin
        live  <= live + 1'b1;
        ovf_o <= (live == C_PRE);
      end
    end
  end

  assign count_o = latch_mode ? hold : live;

  p_sat_hold_r11: assert property (@(posedge clk) disable iff (rst)
    ((live == C_MAX) && !restart) |=> (live == C_MAX));

  p_ovf_single_r11: assert property (@(posedge clk) disable iff (rst)
    ovf_o |=> !ovf_o);

  p_ovf_at_max_r11: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (live == C_MAX));

  p_hold_stable_r10: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(hold));

endmodule

// File: rtl/prbs_rx_checker.sv
module prbs_rx_checker #(
  parameter int CNT_W    = 16,
  parameter int ZL_W     = 4,
  parameter int TS_W     = 5,
  parameter int LOCK_RUN = 32,
  parameter int WIN_LEN  = 64,
  parameter int WIN_ERR  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             bit_vld,
  input  logic             t1_fbit,
  input  logic [TS_W-1:0]  e1_ts,
  input  logic             mode_e1,
  input  logic             cas_en,
  input  logic [1:0]       pat_sel,
  input  logic [ZL_W-1:0]  zero_lim,
  input  logic             framed_en,
  input  logic             start_en,
  input  logic             reseed,
  input  logic             latch_mode,
  input  logic             sec_tick,
  input  logic             cnt_rd,
  output logic             sync,
  output logic [CNT_W-1:0] err_cnt,
  output logic             ovf_irq
);

  logic use_bit;
  logic err_pulse;

  prbs_slot_gate #(.TS_W(TS_W)) u_gate (
    .bit_vld   (bit_vld),
    .framed_en (framed_en),
    .mode_e1   (mode_e1),
    .cas_en    (cas_en),
    .t1_fbit   (t1_fbit),
    .e1_ts     (e1_ts),
    .use_bit   (use_bit)
  );

  prbs_lock_engine #(
    .LOCK_RUN (LOCK_RUN),
    .WIN_LEN  (WIN_LEN),
    .WIN_ERR  (WIN_ERR),
    .ZL_W     (ZL_W)
  ) u_engine (
    .clk      (clk),
    .rst      (rst),
    .use_bit  (use_bit),
    .rx_bit   (bit_in),
    .start_en (start_en),
    .reseed   (reseed),
    .pat_sel  (pat_sel),
    .zero_lim (zero_lim),
    .sync_o   (sync),
    .err_o    (err_pulse)
  );

  prbs_err_counter #(.CNT_W(CNT_W)) u_count (
    .clk        (clk),
    .rst        (rst),
    .inc        (err_pulse),
    .latch_mode (latch_mode),
    .rd_clr     (cnt_rd),
    .tick       (sec_tick),
    .count_o    (err_cnt),
    .ovf_o      (ovf_irq)
  );

endmodule

// File: tb/prbs_rx_checker_bench.sv
`timescale 1ns/1ps
module prbs_rx_checker_bench;

  localparam int CW = 10;

  logic clk = 1'b0;
  logic rst;
  logic bit_in, bit_vld, t1_fbit, mode_e1, cas_en, framed_en, start_en;
  logic reseed, latch_mode, sec_tick, cnt_rd;
  logic [4:0] e1_ts;
  logic [1:0] pat_sel;
  logic [3:0] zero_lim;
  logic sync, ovf_irq;
  logic [CW-1:0] err_cnt;

  int total = 0, bad = 0, ovf_seen = 0, paybits = 0;
  logic done = 1'b0;
  logic [22:0] g;
  int zr, t1pos;
  logic gtog;
  logic [7:0] e1pos;

  typedef struct packed {
    logic [1:0] sel; logic fr; logic e1; logic cas; logic [3:0] nerr; logic [3:0] expc;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{2'd0, 1'b0, 1'b0, 1'b0, 4'd3, 4'd3},
    '{2'd1, 1'b1, 1'b0, 1'b0, 4'd5, 4'd5},
    '{2'd2, 1'b1, 1'b1, 1'b0, 4'd4, 4'd4},
    '{2'd3, 1'b1, 1'b1, 1'b1, 4'd6, 4'd6},
    '{2'd3, 1'b0, 1'b1, 1'b0, 4'd2, 4'd2},
    '{2'd0, 1'b1, 1'b1, 1'b1, 4'd0, 4'd0}
  };

  prbs_rx_checker #(.CNT_W(CW)) u_prbs_rx_checker (
    .clk(clk), .rst(rst), .bit_in(bit_in), .bit_vld(bit_vld), .t1_fbit(t1_fbit),
    .e1_ts(e1_ts), .mode_e1(mode_e1), .cas_en(cas_en), .pat_sel(pat_sel),
    .zero_lim(zero_lim), .framed_en(framed_en), .start_en(start_en), .reseed(reseed),
    .latch_mode(latch_mode), .sec_tick(sec_tick), .cnt_rd(cnt_rd),
    .sync(sync), .err_cnt(err_cnt), .ovf_irq(ovf_irq)
  );

  always #2.5 clk = ~clk;

  always @(negedge clk) if (!rst && ovf_irq) ovf_seen++;

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic ref_fb(input logic [22:0] r, input logic [1:0] s);
    case (s)
      2'd0: return r[10] ^ r[8];
      2'd1: return r[14] ^ r[13];
      2'd2: return r[19] ^ r[2];
      default: return r[22] ^ r[17];
    endcase
  endfunction

  function automatic logic is_ovh();
    if (!framed_en) return 1'b0;
    if (mode_e1) return (e1pos[7:3] == 5'd0) || (cas_en && e1pos[7:3] == 5'd16);
    return t1pos == 0;
  endfunction

  task automatic drive_one(input logic b);
    @(negedge clk);
    bit_in = b; bit_vld = 1'b1;
    t1_fbit = (t1pos == 0); e1_ts = e1pos[7:3];
    @(posedge clk); #1;
    t1pos = (t1pos == 192) ? 0 : t1pos + 1;
    e1pos = e1pos + 8'd1;
  endtask

  task automatic idle_cycle(input logic rs, input logic rd, input logic tk);
    @(negedge clk);
    bit_vld = 1'b0; reseed = rs; cnt_rd = rd; sec_tick = tk;
    @(posedge clk); #1;
    reseed = 1'b0; cnt_rd = 1'b0; sec_tick = 1'b0;
  endtask

  task automatic send_bit(input logic flip);
    logic raw, ob;
    while (is_ovh()) begin
      drive_one(gtog);
      gtog = ~gtog;
    end
    raw = ref_fb(g, pat_sel);
    ob  = (zero_lim != 0 && zr >= int'(zero_lim)) ? 1'b1 : raw;
    g   = {g[21:0], raw};
    zr  = ob ? 0 : ((zr < 31) ? zr + 1 : 31);
    drive_one(ob ^ flip);
    paybits++;
  endtask

  task automatic restart_stream();
    g = '1; zr = 0; gtog = 1'b0; t1pos = 0; e1pos = 8'd0;
  endtask

  task automatic wait_sync(input int max);
    for (int i = 0; i < max && !sync; i++) send_bit(1'b0);
    paybits = 0;
  endtask

  task automatic lock_up(input string tag);
    idle_cycle(1'b1, 1'b0, 1'b0);
    wait_sync(400);
    chk(sync == 1'b1, tag, sync, 1);
  endtask

  task automatic spaced_errors(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      send_bit(1'b1);
      repeat (gap) send_bit(1'b0);
    end
    repeat (4) send_bit(1'b0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    rst = 1'b1; bit_in = 0; bit_vld = 0; t1_fbit = 0; e1_ts = 0; mode_e1 = 0;
    cas_en = 0; pat_sel = 0; zero_lim = 0; framed_en = 0; start_en = 0;
    reseed = 0; latch_mode = 0; sec_tick = 0; cnt_rd = 0;
    restart_stream();
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(posedge clk); #1;
    chk(sync == 0 && err_cnt == 0 && ovf_irq == 0, "reset state", err_cnt, 0);

    // vector table walk: R1 with R3/R4/R5 framing variants
    for (int v = 0; v < 6; v++) begin
      pat_sel = VEC[v].sel; framed_en = VEC[v].fr; mode_e1 = VEC[v].e1;
      cas_en = VEC[v].cas; zero_lim = 0; latch_mode = 0; start_en = 1;
      restart_stream();
      lock_up("R1 table lock");
      idle_cycle(1'b0, 1'b1, 1'b0);
      spaced_errors(VEC[v].nerr, 19);
      if (!VEC[v].fr)
        chk(err_cnt == VEC[v].expc && sync, "R5 unframed count", err_cnt, VEC[v].expc);
      else if (!VEC[v].e1)
        chk(err_cnt == VEC[v].expc && sync, "R3 T1 framed count", err_cnt, VEC[v].expc);
      else
        chk(err_cnt == VEC[v].expc && sync, "R4 E1 framed count", err_cnt, VEC[v].expc);
    end

    // R9: read strobe clears the live count
    idle_cycle(1'b0, 1'b1, 1'b0);
    @(negedge clk);
    chk(err_cnt == 0, "R9 read clear", err_cnt, 0);

    // R6: start low keeps sync low; start high alone does not hunt
    framed_en = 0; mode_e1 = 0; pat_sel = 2'd1; start_en = 0;
    restart_stream();
    idle_cycle(1'b1, 1'b0, 1'b0);
    repeat (80) send_bit(1'b0);
    chk(sync == 0, "R6 start low no sync", sync, 0);
    start_en = 1;
    repeat (80) send_bit(1'b0);
    chk(sync == 0, "R6 no hunt without reseed", sync, 0);

    // R2: mismatches while hunting are not counted
    idle_cycle(1'b1, 1'b1, 1'b0);
    for (int i = 0; i < 30; i++) send_bit(i[0]);
    wait_sync(400);
    chk(sync == 1, "R2 relock after garbage", sync, 1);
    chk(err_cnt == 0, "R2 no count before lock", err_cnt, 0);

    // R7: reseed drops sync at once, then relocks
    idle_cycle(1'b1, 1'b0, 1'b0);
    chk(sync == 0, "R7 reseed drops sync", sync, 1'b0);
    wait_sync(400);
    chk(sync == 1, "R7 relock after reseed", sync, 1);

    // R6: counting halts while start is low
    start_en = 0;
    repeat (5) send_bit(1'b1);
    repeat (4) send_bit(1'b0);
    chk(sync == 0, "R6 sync low after stop", sync, 0);
    chk(err_cnt == 0, "R6 no count while stopped", err_cnt, 0);
    start_en = 1;

    // R8: window threshold, windows aligned to the first bit after lock
    pat_sel = 2'd2;
    restart_stream();
    lock_up("R8 lock");
    idle_cycle(1'b0, 1'b1, 1'b0);
    repeat (7) send_bit(1'b1);
    while (paybits % 64 != 0) send_bit(1'b0);
    chk(sync == 1, "R8 seven errors keep lock", sync, 1);
    repeat (8) send_bit(1'b1);
    chk(sync == 0, "R8 eight errors drop lock", sync, 0);
    wait_sync(400);
    chk(sync == 1, "R8 automatic relock", sync, 1);
    chk(err_cnt == 15, "R8 errors counted while locked", err_cnt, 15);

    // R10: snapshot on tick
    latch_mode = 1;
    idle_cycle(1'b0, 1'b0, 1'b1);
    spaced_errors(5, 19);
    idle_cycle(1'b0, 1'b0, 1'b1);
    chk(err_cnt == 5, "R10 snapshot value", err_cnt, 5);
    spaced_errors(3, 19);
    chk(err_cnt == 5, "R10 held between ticks", err_cnt, 5);
    idle_cycle(1'b0, 1'b0, 1'b1);
    chk(err_cnt == 3, "R10 next snapshot", err_cnt, 3);
    latch_mode = 0;

    // R12: zero limit applied on both sides while locked
    pat_sel = 2'd3;
    restart_stream();
    lock_up("R12 lock");
    idle_cycle(1'b0, 1'b1, 1'b0);
    zero_lim = 4'd3;
    repeat (400) send_bit(1'b0);
    chk(err_cnt == 0, "R12 forced ones match", err_cnt, 0);
    chk(sync == 1, "R12 lock kept", sync, 1);
    zero_lim = 4'd0;

    // R11: saturation and single overflow pulse
    pat_sel = 2'd0;
    restart_stream();
    lock_up("R11 lock");
    idle_cycle(1'b0, 1'b1, 1'b0);
    ovf_seen = 0;
    spaced_errors(1030, 15);
    chk(err_cnt == 1023, "R11 saturated count", err_cnt, 1023);
    chk(ovf_seen == 1, "R11 single overflow pulse", ovf_seen, 1);

    finish_run();
  end

endmodule